// File: doc/BRIEF.md
# ISA Host Address Decoder for a Display Controller

This block sits between the ISA expansion bus and the register and frame-buffer logic of a display controller. It watches the latched upper memory address and the I/O address. From them it forms three things: the two 16-bit-transfer chip selects the bus expects, an internal select for the controller's own I/O register window, and the two byte-lane enables for the data path. Both chip selects are plain combinational functions of the address, so they settle inside the bus setup window.

A memory access that hits the display segment must be able to stall the host. The block pulls the READY pad low while the memory side is busy. It lets the pad float again once that side reports the transfer done. While the controller is in its low-power suspend state, the memory write strobe, the I/O enable and the byte-high enable are treated as inactive. Palette and lookup-table ports inside the register window are kept out of the 16-bit I/O decode, so they stay 8-bit cycles.

Top module: `isa_host_decode`

## Requirements
- R1: `mem_cs16_n` is low exactly when `la_hi` equals 7'h05, the 128 KiB block covering A0000h–BFFFFh. It is combinational in the same cycle and does not depend on strobes or on `suspend`.
- R2: While `io_en_n` is high, `reg_sel` is 0 and `io_cs16_n` is 1, whatever the value of `io_addr`.
- R3: `reg_sel` is 1 exactly when `io_en_n` is low, `suspend` is low and the full 16-bit `io_addr` lies in 3B0h–3DFh. It is combinational.
- R4: `io_cs16_n` is low exactly when `reg_sel` is 1 and `io_addr` is outside 3C6h–3C9h. The addresses 3C6h to 3C9h always leave it high.
- R5: While `suspend` is high, `io_en_n` is treated as high, `mem_wr_n` is treated as high (a write never starts a wait), and `bhe_n` is treated as high (the high lane is never enabled). `mem_rd_n` still works in suspend.
- R6: The block samples its inputs at each rising edge. If it is idle at that edge, `la_hi` is 7'h05, and `mem_rd_n` is low or `mem_wr_n` is low (with `suspend` low), then `rdy_pull_low` is 1 after that edge. A memory strobe at any other `la_hi` never sets `rdy_pull_low`.
- R7: `rdy_pull_low` stays 1 until a rising edge samples `xfer_done` high, and is 0 after that edge. A value of 1 means the READY pad is driven low; a value of 0 means the pad is at high impedance and never driven high.
- R8: After `rdy_pull_low` is released, no new wait starts until a rising edge samples both memory strobes inactive (with a suspended write counting as inactive). The edge after that one may start a new wait.
- R9: A cycle is active when a memory strobe is effective and `la_hi` hits, or when `reg_sel` is 1 and `io_rd_n` or `io_wr_n` is low. The lane enables use `io_addr[0]` and the effective byte-high enable. Even address with high enable: both lanes. Even address without it: low lane only. Odd address with high enable: high lane only. Odd address without it: low lane only. An inactive cycle enables no lane.
- R10: A rising edge with `rst` high leaves `rdy_pull_low` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| la_hi | input | 7 | Latched upper memory address bits 23..17 |
| io_addr | input | 16 | System address bits 15..0; bit 0 also selects the byte lane |
| io_en_n | input | 1 | I/O decode enable, low to enable (AEN style) |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| bhe_n | input | 1 | Byte-high enable, active low |
| suspend | input | 1 | Suspend mode flag |
| xfer_done | input | 1 | Memory side reports the transfer complete |
| mem_cs16_n | output | 1 | 16-bit memory chip select, active low |
| io_cs16_n | output | 1 | 16-bit I/O chip select, active low |
| reg_sel | output | 1 | Internal I/O register window select |
| byte_lo_en | output | 1 | Low data byte enabled |
| byte_hi_en | output | 1 | High data byte enabled |
| rdy_pull_low | output | 1 | 1 drives READY low, 0 leaves it at high impedance |

## Verification
The chip selects, `reg_sel` and both lane enables are due in the same cycle as the address and strobes that cause them. `rdy_pull_low` changes only one rising edge after the strobe, `xfer_done` or strobe release that moves it. The bench changes inputs at falling edges and advances its reference model at each rising edge from the values held across that edge. It compares every output 3 ns after the rising edge, when both the combinational results and the one-edge-delayed READY state have settled.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

    typedef enum logic [1:0] {
        RDY_IDLE = 2'd0,
        RDY_HOLD = 2'd1,
        RDY_TAIL = 2'd2
    } rdy_state_t;

    typedef struct packed {
        logic hit;
        logic narrow;
    } io_match_t;

    typedef struct packed {
        logic lo;
        logic hi;
    } lanes_t;

    function automatic lanes_t pick_lanes(logic active, logic odd, logic bhe);
        lanes_t l;
        l.lo = active & ~(odd & bhe);
        l.hi = active & bhe;
        return l;
    endfunction

endpackage

// File: rtl/isa_io_match.sv
module isa_io_match
    import isa_dec_pkg::*;
#(
    parameter int                IO_AW        = 16,
    parameter int                BLOCK_SZ     = 16,
    parameter int                IO_BLOCKS    = 3,
    parameter logic [IO_AW-1:0]  IO_FIRST     = 16'h03B0,
    parameter logic [IO_AW-1:0]  NARROW_FIRST = 16'h03C6,
    parameter logic [IO_AW-1:0]  NARROW_LAST  = 16'h03C9
) (
    input  logic [IO_AW-1:0] io_addr,
    input  logic             enable,
    output io_match_t        m
);
    localparam int BLK_BITS = $clog2(BLOCK_SZ);
    localparam int TAG_W    = IO_AW - BLK_BITS;
    localparam logic [TAG_W-1:0] BASE_TAG = IO_FIRST[IO_AW-1:BLK_BITS];

    logic [IO_BLOCKS-1:0] blk_hit;

    for (genvar g = 0; g < IO_BLOCKS; g++) begin : g_blk
        localparam logic [TAG_W-1:0] TAG_G = BASE_TAG + TAG_W'(g);
        assign blk_hit[g] = (io_addr[IO_AW-1:BLK_BITS] == TAG_G);
    end

    always_comb begin
        m.hit    = enable & (|blk_hit);
        m.narrow = (io_addr >= NARROW_FIRST) && (io_addr <= NARROW_LAST);
    end
endmodule

// File: rtl/isa_lane_sel.sv
module isa_lane_sel
    import isa_dec_pkg::*;
(
    input  logic   active,
    input  logic   odd,
    input  logic   bhe,
    output lanes_t lanes
);
    assign lanes = pick_lanes(active, odd, bhe);
endmodule

// File: rtl/isa_ready_fsm.sv
module isa_ready_fsm
    import isa_dec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic strobe,
    input  logic done,
    output logic pull_low
);
    rdy_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RDY_IDLE: if (req)     state_d = RDY_HOLD;
            RDY_HOLD: if (done)    state_d = RDY_TAIL;
            RDY_TAIL: if (!strobe) state_d = RDY_IDLE;
            default:               state_d = RDY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RDY_IDLE;
        else     state_q <= state_d;
    end

    assign pull_low = (state_q == RDY_HOLD);
endmodule

// File: rtl/isa_host_decode.sv
module isa_host_decode
    import isa_dec_pkg::*;
#(
    parameter int                LA_W         = 7,
    parameter int                IO_AW        = 16,
    parameter logic [LA_W-1:0]   MEM_TAG      = 7'h05,
    parameter int                BLOCK_SZ     = 16,
    parameter int                IO_BLOCKS    = 3,
    parameter logic [IO_AW-1:0]  IO_FIRST     = 16'h03B0,
    parameter logic [IO_AW-1:0]  NARROW_FIRST = 16'h03C6,
    parameter logic [IO_AW-1:0]  NARROW_LAST  = 16'h03C9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LA_W-1:0]  la_hi,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_en_n,
    input  logic             mem_rd_n,
    input  logic             mem_wr_n,
    input  logic             io_rd_n,
    input  logic             io_wr_n,
    input  logic             bhe_n,
    input  logic             suspend,
    input  logic             xfer_done,
    output logic             mem_cs16_n,
    output logic             io_cs16_n,
    output logic             reg_sel,
    output logic             byte_lo_en,
    output logic             byte_hi_en,
    output logic             rdy_pull_low
);
    // Suspend gating of the three inputs that go quiet in low-power mode
    logic io_en_eff, mem_wr_eff, bhe_eff;
    assign io_en_eff  = ~io_en_n  & ~suspend;
    assign mem_wr_eff = ~mem_wr_n & ~suspend;
    assign bhe_eff    = ~bhe_n    & ~suspend;

    logic mem_hit, mem_strobe, io_strobe, active;
    io_match_t io_m;
    lanes_t    lanes;

    assign mem_hit    = (la_hi == MEM_TAG);
    assign mem_strobe = ~mem_rd_n | mem_wr_eff;
    assign io_strobe  = ~io_rd_n | ~io_wr_n;

    isa_io_match #(
        .IO_AW       (IO_AW),
        .BLOCK_SZ    (BLOCK_SZ),
        .IO_BLOCKS   (IO_BLOCKS),
        .IO_FIRST    (IO_FIRST),
        .NARROW_FIRST(NARROW_FIRST),
        .NARROW_LAST (NARROW_LAST)
    ) io_match_i (
        .io_addr(io_addr),
        .enable (io_en_eff),
        .m      (io_m)
    );

    assign active = (mem_hit & mem_strobe) | (io_m.hit & io_strobe);

    isa_lane_sel lane_i (
        .active(active),
        .odd   (io_addr[0]),
        .bhe   (bhe_eff),
        .lanes (lanes)
    );

    isa_ready_fsm ready_i (
        .clk     (clk),
        .rst     (rst),
        .req     (mem_hit & mem_strobe),
        .strobe  (mem_strobe),
        .done    (xfer_done),
        .pull_low(rdy_pull_low)
    );

    assign mem_cs16_n = ~mem_hit;
    assign reg_sel    = io_m.hit;
    assign io_cs16_n  = ~(io_m.hit & ~io_m.narrow);
    assign byte_lo_en = lanes.lo;
    assign byte_hi_en = lanes.hi;
endmodule

// File: rtl/isa_host_decode_chk.sv
module isa_host_decode_chk (
    input logic        clk,
    input logic        rst,
    input logic [6:0]  la_hi,
    input logic [15:0] io_addr,
    input logic        io_en_n,
    input logic        mem_rd_n,
    input logic        mem_wr_n,
    input logic        io_rd_n,
    input logic        io_wr_n,
    input logic        suspend,
    input logic        xfer_done,
    input logic        mem_cs16_n,
    input logic        io_cs16_n,
    input logic        reg_sel,
    input logic        byte_lo_en,
    input logic        byte_hi_en,
    input logic        rdy_pull_low
);
    AST_MEM_CS_RANGE: assert property (@(posedge clk) disable iff (rst)
        (la_hi != 7'h05) |-> mem_cs16_n); // R1
    AST_AEN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        io_en_n |-> (io_cs16_n && !reg_sel)); // R2
    AST_IO_CS_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        !io_cs16_n |-> reg_sel); // R3
    AST_NARROW_8BIT: assert property (@(posedge clk) disable iff (rst)
        (io_addr >= 16'h03C6 && io_addr <= 16'h03C9) |-> io_cs16_n); // R4
    AST_SUSPEND_NO_IO: assert property (@(posedge clk) disable iff (rst)
        suspend |-> (!reg_sel && !byte_hi_en)); // R5
    AST_RDY_START: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_pull_low) |->
        $past(la_hi == 7'h05 && (!mem_rd_n || (!mem_wr_n && !suspend)))); // R6
    AST_RDY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rdy_pull_low && !xfer_done) |=> rdy_pull_low); // R7
    AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rdy_pull_low && xfer_done) |=> !rdy_pull_low); // R7
    AST_RDY_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_pull_low) |=> !rdy_pull_low); // R8
    AST_LANES_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n) |-> !(byte_lo_en || byte_hi_en)); // R9
endmodule

bind isa_host_decode isa_host_decode_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .la_hi       (la_hi),
    .io_addr     (io_addr),
    .io_en_n     (io_en_n),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n),
    .io_rd_n     (io_rd_n),
    .io_wr_n     (io_wr_n),
    .suspend     (suspend),
    .xfer_done   (xfer_done),
    .mem_cs16_n  (mem_cs16_n),
    .io_cs16_n   (io_cs16_n),
    .reg_sel     (reg_sel),
    .byte_lo_en  (byte_lo_en),
    .byte_hi_en  (byte_hi_en),
    .rdy_pull_low(rdy_pull_low)
);

// File: tb/isa_host_decode_tb.sv
module isa_host_decode_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  la_hi = 7'h00;
    logic [15:0] io_addr = 16'h0000;
    logic        io_en_n = 1'b1;
    logic        mem_rd_n = 1'b1, mem_wr_n = 1'b1, io_rd_n = 1'b1, io_wr_n = 1'b1;
    logic        bhe_n = 1'b1, suspend = 1'b0, xfer_done = 1'b0;
    logic        mem_cs16_n, io_cs16_n, reg_sel, byte_lo_en, byte_hi_en, rdy_pull_low;

    int checks = 0;
    int fails  = 0;
    int phase  = 0;   // 0 idle, 1 holding READY low, 2 waiting for strobes to drop
    bit finished = 1'b0;

    always #5 clk = ~clk;

    isa_host_decode dut_i (
        .clk(clk), .rst(rst), .la_hi(la_hi), .io_addr(io_addr), .io_en_n(io_en_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .bhe_n(bhe_n), .suspend(suspend), .xfer_done(xfer_done),
        .mem_cs16_n(mem_cs16_n), .io_cs16_n(io_cs16_n), .reg_sel(reg_sel),
        .byte_lo_en(byte_lo_en), .byte_hi_en(byte_hi_en), .rdy_pull_low(rdy_pull_low)
    );

    function automatic bit m_mem_hit();
        int unsigned base;
        base = int'(la_hi) * 32'h20000;
        return (base >= 32'hA0000) && (base < 32'hC0000);
    endfunction

    function automatic bit m_mem_strobe();
        return (mem_rd_n == 1'b0) || (mem_wr_n == 1'b0 && suspend == 1'b0);
    endfunction

    function automatic bit m_reg_sel();
        int a;
        a = int'(io_addr);
        if (io_en_n || suspend) return 1'b0;
        return (a >= 'h3B0) && (a <= 'h3DF);
    endfunction

    task automatic cmp(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model of the wait-state control, advanced on each edge
    always @(posedge clk) begin
        if (rst) phase = 0;
        else begin
            case (phase)
                0: if (m_mem_hit() && m_mem_strobe()) phase = 1;
                1: if (xfer_done) phase = 2;
                default: if (!m_mem_strobe()) phase = 0;
            endcase
        end
    end

    // compare every output shortly after each rising edge
    always @(posedge clk) begin
        #3;
        if (!finished) begin
            bit sel, narrow, act, bhe, odd, exp_lo, exp_hi;
            int a;
            a      = int'(io_addr);
            sel    = m_reg_sel();
            narrow = (a >= 'h3C6) && (a <= 'h3C9);
            act    = (m_mem_hit() && m_mem_strobe()) || (sel && (!io_rd_n || !io_wr_n));
            bhe    = !bhe_n && !suspend;
            odd    = io_addr[0];
            case ({odd, bhe})
                2'b00: begin exp_lo = act;  exp_hi = 1'b0; end
                2'b01: begin exp_lo = act;  exp_hi = act;  end
                2'b10: begin exp_lo = act;  exp_hi = 1'b0; end
                default: begin exp_lo = 1'b0; exp_hi = act; end
            endcase
            cmp("R1 mem_cs16_n", mem_cs16_n, !m_mem_hit());
            if (suspend)      cmp("R5 reg_sel in suspend", reg_sel, sel);
            else if (io_en_n) cmp("R2 reg_sel with enable high", reg_sel, sel);
            else              cmp("R3 reg_sel", reg_sel, sel);
            cmp("R4 io_cs16_n", io_cs16_n, !(sel && !narrow));
            cmp("R9 byte_lo_en", byte_lo_en, exp_lo);
            cmp(suspend ? "R5 byte_hi_en in suspend" : "R9 byte_hi_en", byte_hi_en, exp_hi);
            if (rst) cmp("R10 rdy_pull_low in reset", rdy_pull_low, 1'b0);
            else     cmp("R6/R7/R8 rdy_pull_low", rdy_pull_low, phase == 1);
        end
    end

    task automatic drive(input logic [6:0] la, input logic [15:0] ad, input logic en_n,
                         input logic mrd, input logic mwr, input logic ird, input logic iwr,
                         input logic bh_n, input logic sus, input logic dn, input int n);
        @(negedge clk);
        la_hi = la; io_addr = ad; io_en_n = en_n;
        mem_rd_n = mrd; mem_wr_n = mwr; io_rd_n = ird; io_wr_n = iwr;
        bhe_n = bh_n; suspend = sus; xfer_done = dn;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic idle(input int n);
        drive(7'h00, 16'h0000, 1'b1, 1, 1, 1, 1, 1'b1, 1'b0, 1'b0, n);
    endtask

    initial begin
        logic [15:0] io_pts [12];
        io_pts = '{16'h03AF, 16'h03B0, 16'h03BF, 16'h03C5, 16'h03C6, 16'h03C8,
                   16'h03C9, 16'h03CA, 16'h03DF, 16'h03E0, 16'h13B0, 16'h03D4};
        repeat (3) @(negedge clk);          // R10: edges with reset held
        rst = 1'b0;
        idle(2);
        // R3/R4: boundary I/O addresses, reads with high byte enabled at even address
        foreach (io_pts[i]) drive(7'h00, io_pts[i], 1'b0, 1, 1, 0, 1, 1'b0, 1'b0, 1'b0, 1);
        // R2: same addresses with decode disabled
        foreach (io_pts[i]) drive(7'h00, io_pts[i], 1'b1, 1, 1, 0, 1, 1'b0, 1'b0, 1'b0, 1);
        // R5: suspend hides I/O decode and high byte
        drive(7'h00, 16'h03D4, 1'b0, 1, 1, 1, 0, 1'b0, 1'b1, 1'b0, 2);
        // R9: odd address, high byte off and on
        drive(7'h00, 16'h03C1, 1'b0, 1, 1, 0, 1, 1'b1, 1'b0, 1'b0, 1);
        drive(7'h00, 16'h03C1, 1'b0, 1, 1, 0, 1, 1'b0, 1'b0, 1'b0, 1);
        idle(1);
        // R1: memory select at and around the display block
        drive(7'h04, 16'h0000, 1'b1, 1, 1, 1, 1, 1'b1, 1'b0, 1'b0, 1);
        drive(7'h06, 16'h0000, 1'b1, 1, 1, 1, 1, 1'b1, 1'b0, 1'b0, 1);
        drive(7'h45, 16'h0000, 1'b1, 1, 1, 1, 1, 1'b1, 1'b0, 1'b0, 1);
        drive(7'h05, 16'h0000, 1'b1, 1, 1, 1, 1, 1'b1, 1'b1, 1'b0, 1);
        // R6/R7/R8: memory read wait, done, strobe still held, then release
        drive(7'h05, 16'h1234, 1'b1, 0, 1, 1, 1, 1'b0, 1'b0, 1'b0, 3);
        drive(7'h05, 16'h1234, 1'b1, 0, 1, 1, 1, 1'b0, 1'b0, 1'b1, 1);
        drive(7'h05, 16'h1234, 1'b1, 0, 1, 1, 1, 1'b0, 1'b0, 1'b0, 3);
        idle(2);
        // R6: read outside the display block gets no wait
        drive(7'h06, 16'h0000, 1'b1, 0, 1, 1, 1, 1'b1, 1'b0, 1'b0, 2);
        // R5: write in suspend gets no wait; read in suspend does
        drive(7'h05, 16'h0000, 1'b1, 1, 0, 1, 1, 1'b1, 1'b1, 1'b0, 3);
        drive(7'h05, 16'h0001, 1'b1, 0, 1, 1, 1, 1'b0, 1'b1, 1'b0, 2);
        drive(7'h05, 16'h0001, 1'b1, 0, 1, 1, 1, 1'b0, 1'b1, 1'b1, 1);
        idle(2);
        // random traffic against the reference model
        for (int k = 0; k < 4000; k++) begin
            logic [6:0]  la;
            logic [15:0] ad;
            logic [3:0]  pick;
            pick = 4'($urandom_range(0, 15));
            la = (pick < 10) ? 7'h05 : 7'($urandom);
            ad = (pick[1:0] != 2'b11) ? 16'h03A8 + 16'($urandom_range(0, 63)) : 16'($urandom);
            drive(la, ad, 1'($urandom_range(0, 3) == 0),
                  1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 3) != 0),
                  1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 3) != 0),
                  1'($urandom), 1'($urandom_range(0, 7) == 0),
                  1'($urandom_range(0, 3) == 0), 1);
        end
        idle(2);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired: actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule